// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns characters written by a host into asynchronous serial frames on a single output line. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop interval of one, one and a half or two bit periods. The line rests high between frames. An 8-bit mode word sets the frame format. A transmit-enable input and a break input act as the command word.

Bit timing comes from a clock-enable input, `bit_tick_i`. Each pulse on it is one tick, and the mode word sets how many ticks make one bit period: 1, 16 or 64. A one-character holding register sits in front of the shift stage. The host can therefore load the next character while the current one is still being sent, and a new frame starts on the same tick that ends the previous stop interval. Two status outputs tell the host when the holding register can take a character and when the transmitter has gone fully quiet. Each frame uses the format that was in the mode word when that frame started.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, `txd_o` is 1, `tx_rdy_o` is 1 and `tx_empty_o` is 1.
- R2: `mode_i[1:0]` sets the ticks per bit period: 2'b01 gives 1, 2'b10 gives 16 and 2'b11 gives 64. With 2'b00, no frame is started and any held character stays held.
- R3: A frame starts with a start bit at 0. Then come the data bits, bit 0 first. `mode_i[3:2]` sets how many are sent: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8.
- R4: When `mode_i[4]` is 1, a parity bit follows the last data bit. With `mode_i[5]`=1 it makes the count of ones over the data and parity bits even; with `mode_i[5]`=0 it makes that count odd.
- R5: `mode_i[7:6]` sets the high stop interval that ends each frame: 2'b01 lasts one bit period, 2'b10 lasts 1.5 bit periods (2 ticks when there is 1 tick per bit) and 2'b11 lasts two bit periods. With 2'b00, no frame is started.
- R6: While `txen_i` is 0, no new frame starts and a held character waits. The character is sent once `txen_i` is set.
- R7: While `brk_i` is 1, `txd_o` is 0 from the same cycle on. When `brk_i` is cleared, the line shows its normal level again.
- R8: A write accepted by `wr_i` clears `tx_rdy_o` on the next cycle. `tx_rdy_o` is set again in the cycle after the character moves into the shift stage. A write made while `tx_rdy_o` is 0 is ignored.
- R9: `tx_empty_o` is 1 only when no character is held and none is being sent. A character that is held when a stop interval ends starts its frame on that same tick, with no idle gap.
- R10: A frame uses the mode word that was present when the frame started. Changing `mode_i` during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick_i | input | 1 | Clock-enable pulse, one per tick of the bit clock |
| mode_i | input | 8 | Frame format word (clock factor, length, parity, stop bits) |
| txen_i | input | 1 | Transmit enable |
| brk_i | input | 1 | Break request; holds the line low |
| wr_i | input | 1 | One-cycle data-register write strobe |
| wdata_i | input | 8 | Character to send |
| txd_o | output | 1 | Serial output line, high when idle |
| tx_rdy_o | output | 1 | Holding register can accept a character |
| tx_empty_o | output | 1 | Nothing held and nothing being sent |

## Verification
A bit counter or a phase register that is wrong shows up on the serial line as a frame with the wrong length. The bench measures this by the tick count at which the next start bit falls, so a single extra or missing tick is caught within one frame. A wrong shift or parity state shows up as a wrong data or parity sample at the centre of the affected bit. A holding register that gets stuck, or that is overwritten, shows up as a flag that never changes, as a missing frame, or as the wrong character in the next frame. Each of these is seen within a few hundred ticks.

// File: rtl/frmtx_pkg.sv
package frmtx_pkg;
  localparam int DATA_W = 8;
  localparam int MODE_W = 8;
  localparam int CNT_W  = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP
  } tx_phase_e;

  // ticks per bit period; zero marks an unsupported setting
  function automatic logic [CNT_W-1:0] fmt_factor(input logic [1:0] sel);
    case (sel)
      2'b01:   return CNT_W'(1);
      2'b10:   return CNT_W'(16);
      2'b11:   return CNT_W'(64);
      default: return '0;
    endcase
  endfunction

  // length of the stop interval in ticks
  function automatic logic [CNT_W-1:0] fmt_stop_ticks(input logic [MODE_W-1:0] m);
    logic [CNT_W-1:0] f;
    f = fmt_factor(m[1:0]);
    case (m[7:6])
      2'b01:   return f;
      2'b10:   return (f == CNT_W'(1)) ? CNT_W'(2) : f + (f >> 1);
      2'b11:   return f << 1;
      default: return '0;
    endcase
  endfunction

  // index of the last data bit (4..7)
  function automatic logic [IDX_W-1:0] fmt_last_idx(input logic [MODE_W-1:0] m);
    return IDX_W'(4) + IDX_W'(m[3:2]);
  endfunction

  function automatic logic fmt_valid(input logic [MODE_W-1:0] m);
    return (m[1:0] != 2'b00) && (m[7:6] != 2'b00);
  endfunction

  function automatic logic fmt_parity(input logic [DATA_W-1:0] d,
                                      input logic [MODE_W-1:0] m);
    logic p;
    p = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (IDX_W'(i) <= fmt_last_idx(m)) p = p ^ d[i];
    return m[5] ? p : ~p;
  endfunction
endpackage

// File: rtl/frmtx_hold.sv
module frmtx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         wr_accept;

  assign wr_accept = wr_i && !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (wr_accept) begin
      full_q <= 1'b1;
      data_q <= data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // R8
  hold_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> full_o);

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && full_o && !take_i) |=> $stable(data_o));
endmodule

// File: rtl/frmtx_bit_timer.sv
module frmtx_bit_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart_i || done_o) cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= cnt_q + CW'(1);
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !restart_i) |-> (cnt_q < limit_i));
endmodule

// File: rtl/frmtx_seq.sv
module frmtx_seq
  import frmtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              txen_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              bit_done_i,
  output logic              take_o,
  output logic              run_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              line_o
);
  localparam logic [MODE_W-1:0] CFG_RST = 8'h4D;

  tx_phase_e         ph_q;
  logic [MODE_W-1:0] cfg_q;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              par_q;
  logic              line_q;
  logic              stop_end;
  logic              can_load;

  assign stop_end = (ph_q == PH_STOP) && bit_done_i;
  assign can_load = (ph_q == PH_IDLE) || stop_end;
  assign take_o   = can_load && hold_full_i && txen_i && fmt_valid(mode_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cfg_q  <= CFG_RST;
      sh_q   <= '0;
      idx_q  <= '0;
      par_q  <= 1'b0;
      line_q <= 1'b1;
    end else if (take_o) begin
      ph_q   <= PH_START;
      cfg_q  <= mode_i;
      sh_q   <= hold_data_i;
      idx_q  <= '0;
      par_q  <= fmt_parity(hold_data_i, mode_i);
      line_q <= 1'b0;
    end else if (bit_done_i) begin
      case (ph_q)
        PH_START: begin
          ph_q   <= PH_DATA;
          idx_q  <= '0;
          line_q <= sh_q[0];
        end
        PH_DATA: begin
          if (idx_q == fmt_last_idx(cfg_q)) begin
            if (cfg_q[4]) begin
              ph_q   <= PH_PAR;
              line_q <= par_q;
            end else begin
              ph_q   <= PH_STOP;
              line_q <= 1'b1;
            end
          end else begin
            idx_q  <= idx_q + IDX_W'(1);
            sh_q   <= sh_q >> 1;
            line_q <= sh_q[1];
          end
        end
        PH_PAR: begin
          ph_q   <= PH_STOP;
          line_q <= 1'b1;
        end
        default: begin
          ph_q   <= PH_IDLE;
          line_q <= 1'b1;
        end
      endcase
    end
  end

  assign run_o   = (ph_q != PH_IDLE);
  assign limit_o = (ph_q == PH_STOP) ? fmt_stop_ticks(cfg_q) : fmt_factor(cfg_q[1:0]);
  assign line_o  = line_q;

  // R6
  txen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txen_i |-> !take_o);

  // R2
  fmt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_valid(mode_i) |-> !take_o);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !stop_end) |=> $stable(cfg_q));
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import frmtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              txen_i,
  input  logic              brk_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_empty_o
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              shift_take;
  logic              shift_run;
  logic              bit_done;
  logic [CNT_W-1:0]  bit_limit;
  logic              line;

  frmtx_hold #(.W(DATA_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_i),
    .data_i (wdata_i),
    .take_i (shift_take),
    .full_o (hold_full),
    .data_o (hold_data)
  );

  frmtx_bit_timer #(.CW(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (shift_run),
    .restart_i (shift_take),
    .tick_i    (bit_tick_i),
    .limit_i   (bit_limit),
    .done_o    (bit_done)
  );

  frmtx_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .txen_i      (txen_i),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .bit_done_i  (bit_done),
    .take_o      (shift_take),
    .run_o       (shift_run),
    .limit_o     (bit_limit),
    .line_o      (line)
  );

  assign txd_o      = line && !brk_i;
  assign tx_rdy_o   = !hold_full;
  assign tx_empty_o = !hold_full && !shift_run;

  // R7
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |-> !txd_o);

  // R9
  empty_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_o |-> tx_rdy_o);

  // R8
  take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_take |=> tx_rdy_o);
endmodule

// File: tb/sim_async_frame_tx.sv
`timescale 1ns/1ps
module sim_async_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic [7:0] mode = 8'h4D;
  logic       txen = 1'b1;
  logic       brk = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       txd, rdy, empty;
  int         tickcnt = 0;
  int         checks = 0;
  int         failures = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) bit_tick <= ~bit_tick;
  always @(posedge clk) if (!rst_n) tickcnt <= 0; else if (bit_tick) tickcnt <= tickcnt + 1;

  async_frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick_i(bit_tick), .mode_i(mode),
    .txen_i(txen), .brk_i(brk), .wr_i(wr), .wdata_i(wdata),
    .txd_o(txd), .tx_rdy_o(rdy), .tx_empty_o(empty)
  );

  function automatic int b_fac(input logic [7:0] m);
    case (m[1:0]) 2'b01: return 1; 2'b10: return 16; 2'b11: return 64; default: return 0; endcase
  endfunction
  function automatic int b_len(input logic [7:0] m);
    return 5 + int'(m[3:2]);
  endfunction
  function automatic int b_stop(input logic [7:0] m);
    int f;
    f = b_fac(m);
    case (m[7:6]) 2'b01: return f; 2'b10: return (f == 1) ? 2 : (3 * f) / 2; default: return 2 * f; endcase
  endfunction
  function automatic int b_bits(input logic [7:0] m);
    return 1 + b_len(m) + int'(m[4]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_to(input int target);
    while (tickcnt < target) @(negedge clk);
  endtask

  task automatic write_chr(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // decode one frame in format m and compare with exp
  task automatic rx_check(input logic [7:0] m, input logic [7:0] exp, output int t0);
    int f, n, st, nb, guard;
    logic [7:0] got;
    logic pb;
    f = b_fac(m); n = b_len(m); st = b_stop(m); nb = b_bits(m);
    guard = 0;
    while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    t0 = tickcnt;
    chk(guard < 20000, "R3", "start bit seen", guard, 0);
    wait_to(t0 + f / 2);
    chk(txd == 1'b0, "R3", "start bit level", int'(txd), 0);
    got = 8'h00;
    for (int k = 0; k < n; k++) begin
      wait_to(t0 + (1 + k) * f + f / 2);
      got[k] = txd;
    end
    chk(got == (exp & 8'((1 << n) - 1)), "R3", "data bits", int'(got), int'(exp & 8'((1 << n) - 1)));
    if (m[4]) begin
      wait_to(t0 + (1 + n) * f + f / 2);
      pb = txd;
      chk(((^got) ^ pb) == ~m[5], "R4", "parity bit", int'(pb), int'(~m[5] ^ (^got)));
    end
    wait_to(t0 + nb * f + st / 2);
    chk(txd == 1'b1, "R5", "stop middle", int'(txd), 1);
    wait_to(t0 + nb * f + st - 1);
    chk(txd == 1'b1, "R5", "stop last tick", int'(txd), 1);
  endtask

  task automatic wait_empty(input string req);
    int g;
    g = 0;
    while (!empty && g < 20000) begin @(negedge clk); g++; end
    chk(empty == 1'b1, req, "tx_empty after frame", int'(empty), 1);
  endtask

  task automatic quiet_check(input int cycles, input string req);
    int lows;
    lows = 0;
    repeat (cycles) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0, req, "line stays high", lows, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(rdy == 1'b1, "R1", "tx_rdy after reset", int'(rdy), 1);
    chk(empty == 1'b1, "R1", "tx_empty after reset", int'(empty), 1);
  endtask

  task automatic t_format(input logic [7:0] m, input logic [7:0] d);
    int t0;
    mode = m;
    fork
      write_chr(d);
      rx_check(m, d, t0);
    join
    chk(rdy == 1'b1, "R8", "tx_rdy back after load", int'(rdy), 1);
    wait_empty("R9");
  endtask

  task automatic t_b2b(input logic [7:0] m, input logic [7:0] d1, input logic [7:0] d2);
    int ta, tb;
    mode = m;
    fork
      begin
        write_chr(d1);
        while (!rdy) @(negedge clk);
        write_chr(d2);
        chk(rdy == 1'b0, "R8", "tx_rdy low while second held", int'(rdy), 0);
        chk(empty == 1'b0, "R9", "tx_empty low while busy", int'(empty), 0);
      end
      begin
        rx_check(m, d1, ta);
        rx_check(m, d2, tb);
      end
    join
    chk(tb - ta == b_bits(m) * b_fac(m) + b_stop(m), "R9", "frame spacing in ticks",
        tb - ta, b_bits(m) * b_fac(m) + b_stop(m));
    wait_empty("R9");
  endtask

  task automatic t_txen();
    int t0;
    mode = 8'h4D; txen = 1'b0;
    write_chr(8'h81);
    quiet_check(100, "R6");
    chk(rdy == 1'b0, "R8", "tx_rdy low while held", int'(rdy), 0);
    chk(empty == 1'b0, "R6", "tx_empty low while held", int'(empty), 0);
    write_chr(8'h7E);
    fork
      rx_check(8'h4D, 8'h81, t0);
      begin @(negedge clk); txen = 1'b1; end
    join
    wait_empty("R6");
    quiet_check(60, "R8");
  endtask

  task automatic t_invalid();
    int t0;
    txen = 1'b1;
    mode = 8'h4C;
    write_chr(8'h55);
    quiet_check(80, "R2");
    chk(empty == 1'b0, "R2", "char held with factor 00", int'(empty), 0);
    mode = 8'h0D;
    quiet_check(80, "R5");
    chk(rdy == 1'b0, "R5", "char held with stop 00", int'(rdy), 0);
    mode = 8'h4D;
    rx_check(8'h4D, 8'h55, t0);
    wait_empty("R2");
  endtask

  task automatic t_break();
    @(negedge clk); brk = 1'b1;
    #1 chk(txd == 1'b0, "R7", "break same cycle", int'(txd), 0);
    repeat (5) @(negedge clk);
    chk(txd == 1'b0, "R7", "break held", int'(txd), 0);
    brk = 1'b0;
    #1 chk(txd == 1'b1, "R7", "line after break", int'(txd), 1);
  endtask

  task automatic t_modechg();
    int t0;
    mode = 8'hBA;
    fork
      write_chr(8'h5B);
      rx_check(8'hBA, 8'h5B, t0);
      begin wait (txd == 1'b0); @(negedge clk); mode = 8'h4D; end
    join
    chk(1'b1, "R10", "frame kept its format", 0, 0);
    wait_empty("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_format(8'h4D, 8'hA5);   // x1, 8 bits, no parity, 1 stop
    t_format(8'hBA, 8'h5B);   // x16, 7 bits, even, 1.5 stop
    t_format(8'hD3, 8'h13);   // x64, 5 bits, odd, 2 stop
    t_format(8'hC6, 8'h2D);   // x16, 6 bits, no parity, 2 stop
    t_format(8'h7D, 8'hFF);   // x1, 8 bits, even, 1 stop
    t_format(8'h59, 8'h00);   // x1, 7 bits, odd, 1 stop
    t_b2b(8'h8D, 8'h3C, 8'hC3); // x1 1.5 stop rounds to 2 ticks
    t_b2b(8'h4E, 8'h96, 8'h69); // x16 1 stop
    t_b2b(8'hB2, 8'h1F, 8'h0A); // x16 5 bits even 1.5 stop
    t_txen();
    t_invalid();
    t_break();
    t_modechg();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule